// File: doc/BRIEF.md
# PPS-Aligned Seconds/Ticks Timekeeper

This block holds absolute time as two 32-bit words, a seconds count and a sub-second tick count. The tick count advances once per clock and wraps at a programmable ticks-per-second limit. Each wrap adds one to the seconds count. Software programs the block over a simple settings write port: a strobe, an address and a 32-bit data word. It stages a new seconds and tick value, then writes a load-control register. That write either applies the staged time on the next clock or arms the block to apply it on the next qualifying pulse-per-second (PPS) edge.

There are two asynchronous PPS inputs. Each passes through a two-flop synchronizer and then an edge detector. A flag register picks the input and the edge polarity. Every qualifying edge copies the running time into a snapshot pair, so the time at the last second boundary can be read beside the live time.

Load sequencing is a two-state machine. `TK_IDLE` means no load is pending. `TK_ARMED` means a deferred load waits for a PPS edge. Its transitions are as follows:
- **arm**: IDLE goes to ARMED on a deferred-load request.
- **fire**: ARMED goes to IDLE on a qualifying edge, and the staged time is applied.
- **cancel**: ARMED goes to IDLE on an immediate-load request, and the staged time is applied at once.
- **rearm**: ARMED stays ARMED on a further deferred request, or on a deferred request that coincides with an edge.

In IDLE, an immediate request applies the staged time and the state stays IDLE.

Top module: `pps_timekeeper`

## Requirements
- R1: During and right after reset, the live time and the snapshot read 0/0. The flags default to falling edge on input A, so a rising edge on input A alone leaves the snapshot at 0.
- R2: With no load taking effect, ticks rise by one per clock. When ticks equal limit-1, ticks become 0 and seconds rise by one in the same clock.
- R3: Writing register offset 4 sets the ticks-per-second limit. The limit governs every later wrap.
- R4: Writes to offset 0 (seconds) and offset 1 (ticks) only stage values. The live time keeps counting unaffected.
- R5: Writing offset 3 with data bit 0 = 1 makes the live time equal the staged pair on the clock after the write clock. Counting resumes from there.
- R6: Writing offset 3 with data bit 0 = 0 arms a deferred load. The load stays pending until the first qualifying PPS edge, is applied exactly once, and then clears.
- R7: Flag register offset 2, bit 0 selects the qualifying edge: 0 = falling, 1 = rising.
- R8: Flag register offset 2, bit 1 selects the PPS input: 0 = input A (`pps_a`), 1 = input B (`pps_b`). Edges on the other input have no effect.
- R9: A PPS pin change seen first at rising clock edge e1 takes effect at edge e3. After e3, the live time holds the loaded value if a load was pending, and the snapshot holds the live time shown between e2 and e3.
- R10: Every qualifying edge updates the snapshot, whether or not a load is pending.
- R11: When a deferred load fires, the snapshot takes the time from before the load, and the live time takes the staged value.
- R12: An immediate load while armed cancels the deferred load. A later PPS edge then changes only the snapshot.
- R13: Writes to addresses outside the five offsets from `SET_BASE` (default 16) change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| set_stb | input | 1 | Settings write strobe, one cycle per write |
| set_addr | input | ADDR_W (8) | Settings register address |
| set_data | input | 32 | Settings write data |
| pps_a | input | 1 | Asynchronous PPS input A |
| pps_b | input | 1 | Asynchronous PPS input B |
| now_secs | output | 32 | Live seconds |
| now_ticks | output | 32 | Live ticks within the second |
| snap_secs | output | 32 | Seconds captured at last qualifying PPS edge |
| snap_ticks | output | 32 | Ticks captured at last qualifying PPS edge |

## Verification
Two actions can land in the same clock. One is the arrival of a qualifying PPS edge, which snapshots the time and fires a deferred load. The other is a tick wrap or an immediate-load request. The bench arms a deferred load and then drives the selected PPS pin, so that the edge matures while the counter runs. It then judges against its behavioural model that the snapshot took the pre-load time while the live time took the staged value. It also issues an immediate load over an armed one and confirms that the later edge no longer reloads.

// File: rtl/tk_pkg.sv
package tk_pkg;

    localparam int TK_W      = 32;
    localparam int NUM_REGS  = 5;

    // register offsets from the block base address
    localparam int IDX_SECS  = 0;
    localparam int IDX_TICKS = 1;
    localparam int IDX_FLAGS = 2;
    localparam int IDX_IMM   = 3;
    localparam int IDX_TPS   = 4;

    typedef struct packed {
        logic [TK_W-1:0] secs;
        logic [TK_W-1:0] ticks;
    } tk_time_t;

    typedef enum logic [0:0] {
        TK_IDLE  = 1'b0,
        TK_ARMED = 1'b1
    } tk_state_e;

endpackage

// File: rtl/tk_pps_sync.sv
module tk_pps_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);

    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], pin};
            last  <= chain[TOP];
        end
    end

    assign rise =  chain[TOP] & ~last;
    assign fall = ~chain[TOP] &  last;

    generate
        if (STAGES == 2) begin : g_lat_chk
            // R9
            sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
                rise |-> $past(pin, 2));
        end
    endgenerate

endmodule

// File: rtl/tk_regs.sv
module tk_regs
    import tk_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SET_BASE = 16,
    parameter logic [TK_W-1:0]   TPS_INIT = 32'd100_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TK_W-1:0]   data,
    output tk_time_t          stage,
    output logic              edge_rise,
    output logic              src_b,
    output logic [TK_W-1:0]   tps,
    output logic              load_now,
    output logic              load_arm
);

    localparam logic [ADDR_W-1:0] LAST_OFF = ADDR_W'(NUM_REGS - 1);

    logic [ADDR_W-1:0] off;
    logic              hit;

    assign off = addr - SET_BASE;
    assign hit = stb && (addr >= SET_BASE) && (off <= LAST_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage     <= '0;
            edge_rise <= 1'b0;
            src_b     <= 1'b0;
            tps       <= TPS_INIT;
            load_now  <= 1'b0;
            load_arm  <= 1'b0;
        end else begin
            load_now <= 1'b0;
            load_arm <= 1'b0;
            if (hit) begin
                case (off)
                    ADDR_W'(IDX_SECS):  stage.secs  <= data;
                    ADDR_W'(IDX_TICKS): stage.ticks <= data;
                    ADDR_W'(IDX_FLAGS): begin
                        edge_rise <= data[0];
                        src_b     <= data[1];
                    end
                    ADDR_W'(IDX_IMM): begin
                        load_now <=  data[0];
                        load_arm <= ~data[0];
                    end
                    ADDR_W'(IDX_TPS):   tps <= data;
                    default: ;
                endcase
            end
        end
    end

    // R13
    ignore_write_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && !hit) |=> ($stable(tps) && $stable(stage) && $stable({edge_rise, src_b})
                           && !load_now && !load_arm));

    // R4
    stage_only_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && off == ADDR_W'(IDX_SECS)) |=> (stage.secs == $past(data) && !load_now && !load_arm));

endmodule

// File: rtl/tk_clock.sv
module tk_clock
    import tk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  tk_time_t        stage,
    input  logic [TK_W-1:0] tps,
    input  logic            load_now,
    input  logic            load_arm,
    input  logic            pps_evt,
    output tk_time_t        now_t,
    output tk_time_t        snap_t
);

    tk_state_e state_q, state_d;
    logic      take_load;
    logic      at_wrap;

    assign at_wrap = (now_t.ticks == tps - TK_W'(1));

    // next-state and load decision
    always_comb begin
        state_d   = state_q;
        take_load = 1'b0;
        unique case (state_q)
            TK_IDLE: begin
                if (load_now) begin
                    take_load = 1'b1;
                end else if (load_arm) begin
                    state_d = TK_ARMED;
                end
            end
            TK_ARMED: begin
                if (load_now) begin
                    take_load = 1'b1;
                    state_d   = TK_IDLE;
                end else if (pps_evt) begin
                    take_load = 1'b1;
                    state_d   = load_arm ? TK_ARMED : TK_IDLE;
                end
            end
            default: state_d = TK_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= TK_IDLE;
        else     state_q <= state_d;
    end

    // time outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            now_t  <= '0;
            snap_t <= '0;
        end else begin
            if (take_load) begin
                now_t <= stage;
            end else if (at_wrap) begin
                now_t.ticks <= '0;
                now_t.secs  <= now_t.secs + TK_W'(1);
            end else begin
                now_t.ticks <= now_t.ticks + TK_W'(1);
            end
            if (pps_evt) snap_t <= now_t;
        end
    end

    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!take_load && !at_wrap) |=> (now_t.ticks == $past(now_t.ticks) + 1
                                      && now_t.secs == $past(now_t.secs)));

    // R2
    tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!take_load && at_wrap) |=> (now_t.ticks == '0 && now_t.secs == $past(now_t.secs) + 1));

    // R5
    now_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_now |=> (now_t == $past(stage)));

    // R6
    armed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == TK_ARMED && !pps_evt && !load_now) |=> state_q == TK_ARMED);

    // R12
    cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == TK_ARMED && load_now) |=> state_q == TK_IDLE);

    // R11
    snap_pre_load_chk: assert property (@(posedge clk) disable iff (rst)
        pps_evt |=> (snap_t == $past(now_t)));

endmodule

// File: rtl/pps_timekeeper.sv
module pps_timekeeper
    import tk_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] SET_BASE    = 16,
    parameter logic [TK_W-1:0]   TPS_INIT    = 32'd100_000_000,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_stb,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic [TK_W-1:0]   set_data,
    input  logic              pps_a,
    input  logic              pps_b,
    output logic [TK_W-1:0]   now_secs,
    output logic [TK_W-1:0]   now_ticks,
    output logic [TK_W-1:0]   snap_secs,
    output logic [TK_W-1:0]   snap_ticks
);

    localparam int NUM_PPS = 2;

    tk_time_t          stage, now_t, snap_t;
    logic [TK_W-1:0]   tps;
    logic              edge_rise, src_b, load_now, load_arm, pps_evt;
    logic [NUM_PPS-1:0] pins, rises, falls;

    assign pins = {pps_b, pps_a};

    tk_regs #(
        .ADDR_W  (ADDR_W),
        .SET_BASE(SET_BASE),
        .TPS_INIT(TPS_INIT)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .stb      (set_stb),
        .addr     (set_addr),
        .data     (set_data),
        .stage    (stage),
        .edge_rise(edge_rise),
        .src_b    (src_b),
        .tps      (tps),
        .load_now (load_now),
        .load_arm (load_arm)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_PPS; gi++) begin : g_sync
            tk_pps_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk (clk),
                .rst (rst),
                .pin (pins[gi]),
                .rise(rises[gi]),
                .fall(falls[gi])
            );
        end
    endgenerate

    always_comb begin
        if (edge_rise) pps_evt = rises[src_b];
        else           pps_evt = falls[src_b];
    end

    tk_clock u_clock (
        .clk     (clk),
        .rst     (rst),
        .stage   (stage),
        .tps     (tps),
        .load_now(load_now),
        .load_arm(load_arm),
        .pps_evt (pps_evt),
        .now_t   (now_t),
        .snap_t  (snap_t)
    );

    assign now_secs   = now_t.secs;
    assign now_ticks  = now_t.ticks;
    assign snap_secs  = snap_t.secs;
    assign snap_ticks = snap_t.ticks;

    // R8
    unselected_src_chk: assert property (@(posedge clk) disable iff (rst)
        (!rises[src_b] && !falls[src_b]) |=> $stable(snap_t));

endmodule

// File: tb/sim_pps_timekeeper.sv
module sim_pps_timekeeper;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] BASE = 8'd16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        set_stb = 1'b0;
    logic [7:0]  set_addr = '0;
    logic [31:0] set_data = '0;
    logic        pps_a = 1'b0;
    logic        pps_b = 1'b0;
    logic [31:0] now_secs, now_ticks, snap_secs, snap_ticks;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pps_timekeeper u0 (
        .clk(clk), .rst(rst), .set_stb(set_stb), .set_addr(set_addr), .set_data(set_data),
        .pps_a(pps_a), .pps_b(pps_b),
        .now_secs(now_secs), .now_ticks(now_ticks),
        .snap_secs(snap_secs), .snap_ticks(snap_ticks)
    );

    // behavioural reference model
    logic [31:0] m_secs, m_ticks, m_snap_s, m_snap_t, m_tps, m_stg_s, m_stg_t;
    logic        m_rise, m_srcb, m_armed, m_p_now, m_p_arm, m_evt;
    logic [2:0]  hist_a, hist_b;   // [0] newest sample
    logic [2:0]  hsel;
    logic [31:0] old_s, old_t;
    int          off;

    always @(posedge clk) begin
        if (rst) begin
            m_secs = 0; m_ticks = 0; m_snap_s = 0; m_snap_t = 0;
            m_tps = 32'd100_000_000; m_stg_s = 0; m_stg_t = 0;
            m_rise = 0; m_srcb = 0; m_armed = 0; m_p_now = 0; m_p_arm = 0;
            hist_a = 0; hist_b = 0;
        end else begin
            hsel  = m_srcb ? hist_b : hist_a;
            m_evt = m_rise ? (hsel[1] && !hsel[2]) : (!hsel[1] && hsel[2]);
            old_s = m_secs; old_t = m_ticks;
            if (m_p_now) begin
                m_secs = m_stg_s; m_ticks = m_stg_t; m_armed = 0;
            end else if (m_armed && m_evt) begin
                m_secs = m_stg_s; m_ticks = m_stg_t; m_armed = 0;
            end else if (m_ticks == m_tps - 32'd1) begin
                m_ticks = 0; m_secs = m_secs + 1;
            end else begin
                m_ticks = m_ticks + 1;
            end
            if (m_p_arm) m_armed = 1;
            if (m_evt) begin m_snap_s = old_s; m_snap_t = old_t; end
            m_p_now = 0; m_p_arm = 0;
            if (set_stb && set_addr >= BASE && set_addr < BASE + 8'd5) begin
                off = int'(set_addr - BASE);
                case (off)
                    0: m_stg_s = set_data;
                    1: m_stg_t = set_data;
                    2: begin m_rise = set_data[0]; m_srcb = set_data[1]; end
                    3: begin m_p_now = set_data[0]; m_p_arm = !set_data[0]; end
                    default: m_tps = set_data;
                endcase
            end
            hist_a = {hist_a[1:0], pps_a};
            hist_b = {hist_b[1:0], pps_b};
        end
    end

    // compare on every clock
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (now_secs !== m_secs || now_ticks !== m_ticks ||
                snap_secs !== m_snap_s || snap_ticks !== m_snap_t) begin
                errors++;
                $display("FAIL %s model: actual now=%0d/%0d snap=%0d/%0d expected now=%0d/%0d snap=%0d/%0d",
                         cur_req, now_secs, now_ticks, snap_secs, snap_ticks,
                         m_secs, m_ticks, m_snap_s, m_snap_t);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_addr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        set_stb = 1'b1; set_addr = a; set_data = d;
        @(negedge clk);
        set_stb = 1'b0;
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        wr_addr(BASE + 8'(idx), d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 now_secs", now_secs, 0);
        chk("R1 now_ticks", now_ticks, 0);
        chk("R1 snap_secs", snap_secs, 0);
        rst = 1'b0;
        idle(4);
        // R1 default: falling edge on input A
        pps_a = 1'b1; idle(6);
        chk("R1 rise ignored by default", snap_ticks, 0);
        pps_a = 1'b0; idle(6);
        chk("R1 falling edge snapshot", snap_ticks, m_snap_t);
        chk("R1 snapshot nonzero", 32'(snap_ticks != 0), 1);

        // R3, R5, R2
        cur_req = "R5";
        wr(4, 32'd10);
        wr(0, 32'd5);
        wr(1, 32'd7);
        wr(3, 32'd1);
        @(negedge clk);
        chk("R5 imm secs", now_secs, 5);
        chk("R5 imm ticks", now_ticks, 7);
        cur_req = "R2";
        idle(3);
        chk("R2 R3 wrap ticks", now_ticks, 0);
        chk("R2 R3 wrap secs", now_secs, 6);

        // R4 staging only
        cur_req = "R4";
        wr(0, 32'd77);
        chk("R4 secs unaffected", now_secs, 6);

        // R7 rising edge, R6 deferred, R9 latency
        cur_req = "R6";
        wr(2, 32'd1);
        wr(1, 32'd3);
        wr(3, 32'd0);
        idle(20);
        chk("R6 no load without edge", 32'(now_secs == 77), 0);
        @(negedge clk); pps_a = 1'b1;
        idle(2);
        chk("R9 not yet at e2", 32'(now_secs == 77), 0);
        idle(1);
        chk("R9 R7 loaded at e3 secs", now_secs, 77);
        chk("R9 R7 loaded at e3 ticks", now_ticks, 3);
        cur_req = "R10";
        pps_a = 1'b0; idle(5);
        pps_a = 1'b1; idle(5);
        chk("R10 second edge snapshot", snap_ticks, m_snap_t);
        chk("R6 applied once", 32'(now_secs >= 77 && now_secs <= 79), 1);

        // R8 source select
        cur_req = "R8";
        wr(2, 32'd3);
        pps_a = 1'b0; idle(5);
        begin
            logic [31:0] held_s, held_t;
            held_s = snap_secs; held_t = snap_ticks;
            pps_a = 1'b1; idle(6);
            chk("R8 input A ignored secs", snap_secs, held_s);
            chk("R8 input A ignored ticks", snap_ticks, held_t);
        end
        pps_b = 1'b1; idle(6);
        chk("R8 input B snapshot", snap_ticks, m_snap_t);

        // R11 deferred load coinciding with snapshot
        cur_req = "R11";
        pps_b = 1'b0;
        wr(4, 32'd1000);
        wr(0, 32'd200);
        wr(1, 32'd0);
        wr(3, 32'd0);
        idle(5);
        @(negedge clk); pps_b = 1'b1;
        idle(3);
        chk("R11 live secs", now_secs, 200);
        chk("R11 live ticks", now_ticks, 0);
        chk("R11 snapshot pre-load", snap_secs, m_snap_s);
        chk("R11 snapshot not staged", 32'(snap_secs == 200), 0);

        // R12 immediate cancels armed load
        cur_req = "R12";
        wr(0, 32'd300);
        wr(3, 32'd0);
        wr(0, 32'd400);
        wr(3, 32'd1);
        @(negedge clk);
        chk("R12 immediate secs", now_secs, 400);
        pps_b = 1'b0; idle(5);
        pps_b = 1'b1; idle(6);
        chk("R12 no reload", now_secs, 400);

        // R13 out-of-range writes
        cur_req = "R13";
        wr_addr(BASE + 8'd5, 32'd0);
        wr_addr(BASE + 8'd7, 32'd0);
        wr_addr(BASE - 8'd1, 32'd5);
        pps_b = 1'b0; idle(5);
        pps_b = 1'b1; idle(6);
        chk("R13 flags kept", snap_ticks, m_snap_t);
        chk("R13 time kept", now_secs, 400);
        idle(10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule